// File: doc/BRIEF.md
# Nine-Bit Command/Data Serial Writer

This block sends register writes to a display controller over a write-only serial link. A host asks for one transfer by pulsing a start strobe. The request carries a command byte, a data count of zero, one or two, and a 16-bit data value. The block then sends one frame under a single chip-select window: the command word first, followed by the data words the count asks for. The link has no return line, so the block only drives. It never samples any input from the peripheral.

Every serial word is nine bits long and is shifted most significant bit first. The top bit is a type flag: 0 marks a command and 1 marks data. The low eight bits carry the byte. When a 16-bit value is sent, it goes as two data words, upper byte first. The serial clock idles high. The peripheral samples on the rising edge, so the block changes the data line only on falling edges. Each half of a bit period lasts a fixed number of system clock cycles, set by a parameter.

Top module: `spi9_cmd_writer`

## Requirements
- R1: Every frame begins with a command word: flag bit 0, then the eight command bits MSB first, so nine bits in all.
- R2: With a data count of 1, one data word follows the command: flag bit 1, then `req_data[7:0]` MSB first.
- R3: With a data count of 2, two data words follow the command: first `{1, req_data[15:8]}`, then `{1, req_data[7:0]}`.
- R4: With a data count of 0, the frame is the command word alone (nine rising clock edges). A count of 3 is handled exactly like a count of 2.
- R5: `spi_sclk` is high whenever `spi_cs_n` is high. Within a frame, `spi_mosi` changes only while `spi_sclk` is low, and never during a high phase.
- R6: `spi_cs_n` falls while `spi_sclk` is high. The first falling clock edge follows HALF_CYCLES system cycles later. `spi_cs_n` then stays low until the frame's last bit has been clocked.
- R7: `spi_cs_n` rises HALF_CYCLES system cycles after the last rising clock edge. `req_done` is high for exactly that one cycle, in which chip select is released, and at no other time.
- R8: Between two frames, `spi_cs_n` stays high for at least 2*HALF_CYCLES system cycles, even when requests arrive back to back.
- R9: `req_busy` rises in the cycle after a start is accepted and stays high until the end of the post-frame gap. A start seen while `req_busy` is high is ignored and launches no frame.
- R10: After reset, `spi_cs_n`=1, `spi_sclk`=1, `spi_mosi`=0, `req_busy`=0 and `req_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Request strobe, accepted only while idle |
| req_cmd | input | 8 | Command byte |
| req_count | input | 2 | Number of data words (0..2, 3 acts as 2) |
| req_data | input | 16 | Data value; low byte for one word, both bytes for two |
| req_busy | output | 1 | Transfer or inter-frame gap in progress |
| req_done | output | 1 | One-cycle pulse when chip select is released |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data out |

## Verification
The bench watches the bus and rebuilds each frame from the data-line values at rising clock edges. It compares the result with a frame built by its own function, so a swapped byte order, a wrong type flag or a missing data word shows up as a mismatched bit string or a wrong bit count. Count 3 and count 0 are driven directly. A design that decoded count 3 as a single word, or sent an empty data word after a bare command, would produce the wrong length.

Starts are fired in the middle of a frame and during the post-frame gap. A design that took them would restart the shifter or emit an extra frame, and the frame tally would move. The spacing between edges is measured in cycles. A design that released chip select at the last rising edge, pulsed done late, or shortened the gap would fail the tail, done or spacing checks. Data changing during a high clock phase is also flagged.

// File: rtl/spi9_pkg.sv
package spi9_pkg;
  localparam int WORD_W    = 9;
  localparam int BYTE_W    = 8;
  localparam int MAX_WORDS = 3;
  localparam int FRAME_W   = WORD_W * MAX_WORDS;
  localparam int LEFT_W    = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LEAD = 3'd1,
    PH_LOW  = 3'd2,
    PH_HIGH = 3'd3,
    PH_GAP  = 3'd4
  } phase_e;

  function automatic logic [WORD_W-1:0] make_word(input logic is_data,
                                                  input logic [BYTE_W-1:0] b);
    make_word = {is_data, b};
  endfunction
endpackage

// File: rtl/spi9_half_timer.sv
module spi9_half_timer #(
  parameter int HALF_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi9_frame_packer.sv
module spi9_frame_packer
  import spi9_pkg::*;
(
  input  logic [BYTE_W-1:0]   cmd,
  input  logic [1:0]          count,
  input  logic [2*BYTE_W-1:0] data,
  output logic [FRAME_W-1:0]  frame,
  output logic [LEFT_W-1:0]   bit_total
);
  logic [1:0] ndata;
  logic [1:0] nwords_m1;

  always_comb begin
    ndata     = (count > 2'd2) ? 2'd2 : count;
    nwords_m1 = ndata;
    bit_total = LEFT_W'(WORD_W) * (LEFT_W'(nwords_m1) + 1'b1);
  end

  assign frame[FRAME_W-1 -: WORD_W] = make_word(1'b0, cmd);

  for (genvar s = 1; s < MAX_WORDS; s++) begin : g_slot
    logic [BYTE_W-1:0] sel_byte;
    always_comb begin
      sel_byte = '0;
      for (int b = 0; b < 2; b++) begin
        if (int'(ndata) - s == b) sel_byte = data[b*BYTE_W +: BYTE_W];
      end
    end
    assign frame[FRAME_W-1-s*WORD_W -: WORD_W] =
      (s <= int'(ndata)) ? make_word(1'b1, sel_byte) : '0;
  end
endmodule

// File: rtl/spi9_shift_fsm.sv
module spi9_shift_fsm
  import spi9_pkg::*;
#(
  parameter int HALF_CYCLES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic [LEFT_W-1:0]  bit_total,
  input  logic               tick,
  output logic               busy,
  output logic               done,
  output logic               cs_n,
  output logic               sclk,
  output logic               mosi
);
  phase_e             ph_q, ph_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [LEFT_W-1:0]  left_q, left_d;
  logic               gap_q, gap_d;
  logic               cs_q, cs_d, sclk_q, sclk_d, mosi_q, mosi_d, done_q, done_d;

  assign busy = (ph_q != PH_IDLE);
  assign done = done_q;
  assign cs_n = cs_q;
  assign sclk = sclk_q;
  assign mosi = mosi_q;

  always_comb begin
    ph_d   = ph_q;
    sh_d   = sh_q;
    left_d = left_q;
    gap_d  = gap_q;
    cs_d   = cs_q;
    sclk_d = sclk_q;
    mosi_d = mosi_q;
    done_d = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start) begin
        ph_d   = PH_LEAD;
        cs_d   = 1'b0;
        sh_d   = frame;
        mosi_d = frame[FRAME_W-1];
        left_d = bit_total - 1'b1;
      end
      PH_LEAD: if (tick) begin
        sclk_d = 1'b0;
        ph_d   = PH_LOW;
      end
      PH_LOW: if (tick) begin
        sclk_d = 1'b1;
        ph_d   = PH_HIGH;
      end
      PH_HIGH: if (tick) begin
        if (left_q == '0) begin
          cs_d   = 1'b1;
          done_d = 1'b1;
          mosi_d = 1'b0;
          gap_d  = 1'b0;
          ph_d   = PH_GAP;
        end else begin
          sclk_d = 1'b0;
          mosi_d = sh_q[FRAME_W-2];
          sh_d   = {sh_q[FRAME_W-2:0], 1'b0};
          left_d = left_q - 1'b1;
          ph_d   = PH_LOW;
        end
      end
      PH_GAP: if (tick) begin
        if (gap_q) ph_d = PH_IDLE;
        else       gap_d = 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      sh_q   <= '0;
      left_q <= '0;
      gap_q  <= 1'b0;
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      sh_q   <= sh_d;
      left_q <= left_d;
      gap_q  <= gap_d;
      cs_q   <= cs_d;
      sclk_q <= sclk_d;
      mosi_q <= mosi_d;
      done_q <= done_d;
    end
  end

  // Cycles chip select has been high, saturating; used by the spacing check.
  localparam int HW = $clog2(2*HALF_CYCLES + 2) + 1;
  localparam logic [HW-1:0] HMAX = {HW{1'b1}};
  logic [HW-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             hi_cnt <= HMAX;
    else if (!cs_q)         hi_cnt <= '0;
    else if (hi_cnt != HMAX) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_clock_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> sclk_q);
  assert_data_steady_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_q && sclk_q && $past(sclk_q) && !$past(cs_q)) |-> $stable(mosi_q));
  assert_select_from_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> ($past(start) && !$past(busy)));
  assert_done_at_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $rose(cs_q));
  assert_idle_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_q);
  assert_frame_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> (hi_cnt >= HW'(2*HALF_CYCLES)));
endmodule

// File: rtl/spi9_cmd_writer.sv
module spi9_cmd_writer
  import spi9_pkg::*;
#(
  parameter int HALF_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_start,
  input  logic [7:0]  req_cmd,
  input  logic [1:0]  req_count,
  input  logic [15:0] req_data,
  output logic        req_busy,
  output logic        req_done,
  output logic        spi_cs_n,
  output logic        spi_sclk,
  output logic        spi_mosi
);
  logic [FRAME_W-1:0] frame;
  logic [LEFT_W-1:0]  bit_total;
  logic               tick;
  logic               busy_i;

  assign req_busy = busy_i;

  spi9_frame_packer u_pack (
    .cmd       (req_cmd),
    .count     (req_count),
    .data      (req_data),
    .frame     (frame),
    .bit_total (bit_total)
  );

  spi9_half_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy_i),
    .tick  (tick)
  );

  spi9_shift_fsm #(.HALF_CYCLES(HALF_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (req_start),
    .frame     (frame),
    .bit_total (bit_total),
    .tick      (tick),
    .busy      (busy_i),
    .done      (req_done),
    .cs_n      (spi_cs_n),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi)
  );
endmodule

// File: tb/spi9_cmd_writer_bench.sv
`timescale 1ns/1ps
module spi9_cmd_writer_bench;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0;
  logic [7:0]  req_cmd = '0;
  logic [1:0]  req_count = '0;
  logic [15:0] req_data = '0;
  logic        req_busy, req_done, spi_cs_n, spi_sclk, spi_mosi;

  always #2.5 clk = ~clk;

  spi9_cmd_writer #(.HALF_CYCLES(HALF)) u_spi9_cmd_writer (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_cmd(req_cmd),
    .req_count(req_count), .req_data(req_data), .req_busy(req_busy),
    .req_done(req_done), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi)
  );

  // Expected frame, right-aligned, and its bit count.
  logic [26:0] exp_val = '0;
  int          exp_len = 0;
  string       exp_req = "R1";

  int m_checks = 0, m_fails = 0, t_checks = 0, t_fails = 0;
  int frames_seen = 0;

  function automatic logic [26:0] model_frame(input logic [7:0] c, input logic [1:0] n,
                                              input logic [15:0] d, output int len);
    logic [26:0] v;
    if (n == 2'd0) begin
      v = {18'd0, 1'b0, c}; len = 9;
    end else if (n == 2'd1) begin
      v = {9'd0, 1'b0, c, 1'b1, d[7:0]}; len = 18;
    end else begin
      v = {1'b0, c, 1'b1, d[15:8], 1'b1, d[7:0]}; len = 27;
    end
    return v;
  endfunction

  // Bus monitor: rebuilds frames and measures edge spacing.
  logic        p_cs = 1'b1, p_sclk = 1'b1, p_mosi = 1'b0;
  logic [26:0] rx = '0;
  int          rx_n = 0, cyc = 0, last_rise = 0, cs_fall = 0, cs_rise = -1000;
  bit          first_fall = 1'b0;

  task automatic mchk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
    m_checks++;
    if (!ok) begin
      m_fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (spi_cs_n && !spi_sclk) mchk(0, "R5", "clock low while deselected", spi_sclk, 1);
      if (!spi_cs_n && !p_cs && spi_sclk && p_sclk && spi_mosi != p_mosi)
        mchk(0, "R5", "data moved in high phase", spi_mosi, p_mosi);
      if (p_cs && !spi_cs_n) begin
        mchk(spi_sclk == 1'b1, "R6", "clock level at select", spi_sclk, 1);
        if (cs_rise >= 0)
          mchk(cyc - cs_rise >= 2*HALF, "R8", "deselect gap", cyc - cs_rise, 2*HALF);
        cs_fall = cyc; rx = '0; rx_n = 0; first_fall = 1'b1;
      end
      if (!spi_cs_n && p_sclk && !spi_sclk && first_fall) begin
        mchk(cyc - cs_fall == HALF, "R6", "lead time", cyc - cs_fall, HALF);
        first_fall = 1'b0;
      end
      if (!spi_cs_n && !p_sclk && spi_sclk) begin
        rx = {rx[25:0], spi_mosi}; rx_n++; last_rise = cyc;
      end
      if (!p_cs && spi_cs_n) begin
        frames_seen++;
        cs_rise = cyc;
        mchk(rx_n == exp_len, exp_req, "bit count", rx_n, exp_len);
        mchk(rx == exp_val, exp_req, "frame bits", rx, exp_val);
        mchk(cyc - last_rise == HALF, "R7", "tail time", cyc - last_rise, HALF);
        mchk(req_done == 1'b1, "R7", "done at release", req_done, 1);
      end else if (req_done) begin
        mchk(0, "R7", "stray done", req_done, 0);
      end
    end
    p_cs = spi_cs_n; p_sclk = spi_sclk; p_mosi = spi_mosi;
  end

  task automatic tchk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
    t_checks++;
    if (!ok) begin
      t_fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic wait_idle();
    while (req_busy) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] c, input logic [1:0] n, input logic [15:0] d,
                      input bit poke_mid);
    int fs;
    int ln;
    wait_idle();
    exp_val = model_frame(c, n, d, ln);
    exp_len = ln;
    exp_req = (n == 2'd0) ? "R4" : (n == 2'd1) ? "R2" : (n == 2'd3) ? "R4" : "R3";
    fs = frames_seen;
    req_cmd = c; req_count = n; req_data = d; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    tchk(req_busy == 1'b1, "R9", "busy after accept", req_busy, 1);
    tchk(spi_cs_n == 1'b0, "R6", "select after accept", spi_cs_n, 0);
    if (poke_mid) begin
      repeat (7) @(negedge clk);
      req_cmd = ~c; req_count = 2'd2; req_data = ~d; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
    end
    while (frames_seen == fs) @(negedge clk);
    tchk(frames_seen == fs + 1, "R9", "frames per request", frames_seen, fs + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tchk(spi_cs_n == 1'b1 && spi_sclk == 1'b1 && spi_mosi == 1'b0 &&
         req_busy == 1'b0 && req_done == 1'b0, "R10", "reset outputs",
         {spi_cs_n, spi_sclk, spi_mosi, req_busy, req_done}, 5'b11000);
    rst_n = 1'b1;
    @(negedge clk);
    tchk(spi_cs_n == 1'b1 && req_busy == 1'b0, "R10", "idle after reset",
         {spi_cs_n, req_busy}, 2'b10);

    // Directed corners: R1 command word alone, R2, R3, R4 count 3.
    send(8'h29, 2'd0, 16'h0000, 0);
    send(8'hB0, 2'd1, 16'hAA11, 0);
    send(8'hB8, 2'd2, 16'hFFF9, 0);
    send(8'h00, 2'd3, 16'h2040, 0);
    send(8'hFF, 2'd2, 16'h8001, 0);
    // R9: start in the middle of a frame is ignored.
    send(8'h3A, 2'd2, 16'h1234, 1);
    // R9: start during the inter-frame gap is ignored.
    begin
      int fs;
      fs = frames_seen;
      tchk(req_busy == 1'b1, "R9", "busy through gap", req_busy, 1);
      req_cmd = 8'h55; req_count = 2'd0; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      repeat (6*HALF + 4) @(negedge clk);
      tchk(frames_seen == fs && spi_cs_n == 1'b1, "R9", "gap start ignored",
           frames_seen, fs);
    end
    // R8: back-to-back requests.
    send(8'h11, 2'd1, 16'h0056, 0);
    send(8'h12, 2'd0, 16'h0000, 0);

    void'($urandom(32'h5EED_0009));
    for (int i = 0; i < 40; i++) begin
      send(8'($urandom), 2'($urandom), 16'($urandom), 1'($urandom % 5 == 0));
    end
    wait_idle();
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures",
             m_checks + t_checks, m_fails + t_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures",
             m_checks + t_checks + 1, m_fails + t_fails + 1);
    $finish;
  end
endmodule